// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This block keeps time as a 32-bit count of seconds. A built-in prescaler divides the core clock by `TICK_DIV` to make a one-cycle tick once per second. On each tick, while counting is switched on, the counter moves one step. Software uses a small word-addressed register bus to do four things: read the count, stage a new count, program a match value, and set the control bits.

A staged count is not written into the counter at once. It is held as pending and replaces the counter value at the next enabled tick. When an enabled tick brings the counter to the match value, a sticky raw alarm flag is set. That flag reaches the level interrupt output only when the interrupt-enable bit is 1 and the mask bit is 0. Reading the end-of-interrupt register clears the flag.

Top module: `sec_rtc_core`

## Requirements
- R1: After reset, these all read 0: the counter (offset 0x00), match (0x04), load (0x08), control (0x0C), masked status (0x10) and raw status (0x14). `irq_o` is 0. Offset 0x1C reads the `VERSION` parameter.
- R2: The prescaler runs from reset whatever the control bits are. It produces one tick on every `TICK_DIV`-th rising clock edge, and the first tick is on edge number `TICK_DIV` after reset is released. When control bit 2 (count enable) is 1, each tick adds 1 to the counter.
- R3: Writing offset 0x08 stages a value without changing the counter. At the next tick with count enable set, the counter takes exactly the staged value, with no increment on that tick.
- R4: While control bit 2 is 0, the counter holds its value and any staged value stays pending. The staged value is applied at the first enabled tick after bit 2 returns to 1.
- R5: Control bit 3 sets the behaviour at the top of the range. When bit 3 is 1, the counter goes from 0xFFFF_FFFF to 0. When bit 3 is 0, it stays at 0xFFFF_FFFF.
- R6: Raw status bit 0 (offset 0x14) is set by an enabled tick that leaves the counter equal to the match value (offset 0x04). This happens whatever the enable and mask bits are, and the bit stays set until it is cleared.
- R7: Masked status bit 0 (offset 0x10) and `irq_o` both equal raw status AND control bit 0 (interrupt enable) AND NOT control bit 1 (mask).
- R8: A read of offset 0x18 returns 0 and clears the raw flag, so `irq_o` falls on the next cycle. If a match occurs in the same cycle as the clearing read, the match wins.
- R9: Read data is valid on the cycle after the read strobe, and is 0 on cycles without a read. Offsets 0x04 and 0x08 return the last value written to them. Offset 0x0C returns control bits [3:0]. Writes to 0x00, 0x10, 0x14, 0x18 and 0x1C change nothing. An unmapped offset reads 0.
- R10: The counter never changes on a clock edge that carries no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
The bench builds the block with `TICK_DIV` = 8, so a one-second tick comes every eight clocks. At that rate, tens of ticks fit into a short run. This puts several behaviours within reach: staged loads applied at the next tick, loads held back while counting is off, and wrap or saturation at the top of the range after a load to 0xFFFF_FFFE. The bench also sets `VERSION` to a distinctive value, so the identifier read can be told apart from zero or stale data.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

  localparam logic [7:0] OFF_COUNT  = 8'h00;
  localparam logic [7:0] OFF_MATCH  = 8'h04;
  localparam logic [7:0] OFF_LOAD   = 8'h08;
  localparam logic [7:0] OFF_CTRL   = 8'h0C;
  localparam logic [7:0] OFF_MSTAT  = 8'h10;
  localparam logic [7:0] OFF_RSTAT  = 8'h14;
  localparam logic [7:0] OFF_EOI    = 8'h18;
  localparam logic [7:0] OFF_VER    = 8'h1C;

  localparam int CTL_IE   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_RUN  = 2;
  localparam int CTL_WRAP = 3;
  localparam int CTL_W    = 4;

  // value the counter takes on an enabled tick
  function automatic logic [31:0] next_count(input logic [31:0] cur,
                                             input logic        pend,
                                             input logic [31:0] staged,
                                             input logic        wrap);
    logic [32:0] sum;
    sum = {1'b0, cur} + 33'd1;
    if (pend)
      return staged;
    else if (sum[32])
      return wrap ? 32'd0 : cur;
    else
      return sum[31:0];
  endfunction

endpackage

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
  parameter int TICK_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] phase_q;

  assign tick_o = (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (tick_o) phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter
  import sec_rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             wrap_i,
  input  logic             wr_load_i,
  input  logic             wr_match_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] staged_o,
  output logic [CNT_W-1:0] match_o,
  output logic             pend_o,
  output logic             step_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] nxt;

  assign step_o = tick_i & run_i;
  assign nxt    = next_count(count_o, pend_o, staged_o, wrap_i);
  assign hit_o  = step_o & (nxt == match_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o  <= '0;
      staged_o <= '0;
      match_o  <= '0;
      pend_o   <= 1'b0;
    end else begin
      if (step_o)     count_o  <= nxt;
      if (wr_load_i)  staged_o <= wdata_i;
      if (wr_match_i) match_o  <= wdata_i;
      if (wr_load_i)  pend_o   <= 1'b1;
      else if (step_o) pend_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clear_i,
  input  logic ie_i,
  input  logic mask_i,
  output logic raw_o,
  output logic masked_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       raw_o <= 1'b0;
    else if (hit_i)   raw_o <= 1'b1;
    else if (clear_i) raw_o <= 1'b0;
  end

  assign masked_o = raw_o & ie_i & ~mask_i;
endmodule

// File: rtl/sec_rtc_core.sv
module sec_rtc_core
  import sec_rtc_pkg::*;
#(
  parameter int          TICK_DIV = 32768,
  parameter int          ADDR_W   = 5,
  parameter logic [31:0] VERSION  = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);
  localparam int CNT_W = 32;

  logic [7:0]       addr8;
  logic [CTL_W-1:0] ctrl_q;
  logic             tick, step, hit, pend, raw, masked, eoi_clr;
  logic             wr_load, wr_match, wr_ctrl;
  logic [CNT_W-1:0] count, staged, match;
  logic [31:0]      rd_mux;

  assign addr8    = 8'(bus_addr);
  assign wr_load  = bus_we & (addr8 == OFF_LOAD);
  assign wr_match = bus_we & (addr8 == OFF_MATCH);
  assign wr_ctrl  = bus_we & (addr8 == OFF_CTRL);
  assign eoi_clr  = bus_re & (addr8 == OFF_EOI);

  sec_rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  sec_rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .run_i(ctrl_q[CTL_RUN]), .wrap_i(ctrl_q[CTL_WRAP]),
    .wr_load_i(wr_load), .wr_match_i(wr_match), .wdata_i(bus_wdata),
    .count_o(count), .staged_o(staged), .match_o(match),
    .pend_o(pend), .step_o(step), .hit_o(hit)
  );

  sec_rtc_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .clear_i(eoi_clr),
    .ie_i(ctrl_q[CTL_IE]), .mask_i(ctrl_q[CTL_MASK]),
    .raw_o(raw), .masked_o(masked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata[CTL_W-1:0];
  end

  always_comb begin
    unique case (addr8)
      OFF_COUNT: rd_mux = count;
      OFF_MATCH: rd_mux = match;
      OFF_LOAD:  rd_mux = staged;
      OFF_CTRL:  rd_mux = 32'(ctrl_q);
      OFF_MSTAT: rd_mux = {31'd0, masked};
      OFF_RSTAT: rd_mux = {31'd0, raw};
      OFF_VER:   rd_mux = VERSION;
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  assign irq_o = masked;
endmodule

// File: rtl/sec_rtc_checker.sv
module sec_rtc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        step,
  input logic        pend,
  input logic        hit,
  input logic        raw,
  input logic        eoi_clr,
  input logic        wrap,
  input logic        irq_o,
  input logic [31:0] count,
  input logic [31:0] staged
);
  // R10: the counter moves only on tick edges
  a_r10_no_sub_second: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R4: with counting off, the counter and the pending load are held
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !step) |=> $stable(count));

  // R3: an enabled tick with a pending load applies the staged value
  a_r3_load_applied: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pend) |=> count == $past(staged));

  // R5: saturation at the top when wrap is off
  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !pend && !wrap && count == 32'hFFFF_FFFF) |=> count == 32'hFFFF_FFFF);

  // R6: the raw flag is sticky until cleared
  a_r6_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !eoi_clr) |=> raw);

  // R8: the clearing read drops the interrupt unless a match coincides
  a_r8_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_clr && !hit) |=> !irq_o);

  // R6: a match always sets the raw flag
  a_r6_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> raw);
endmodule

bind sec_rtc_core sec_rtc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .step(step), .pend(pend),
  .hit(hit), .raw(raw), .eoi_clr(eoi_clr), .wrap(ctrl_q[3]),
  .irq_o(irq_o), .count(count), .staged(staged)
);

// File: tb/sec_rtc_core_bench.sv
module sec_rtc_core_bench;
  localparam int          DIV = 8;
  localparam logic [31:0] VER = 32'hA5C3_0107;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  sec_rtc_core #(.TICK_DIV(DIV), .ADDR_W(5), .VERSION(VER)) u_sec_rtc_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // reference model, written from the requirements
  int          m_phase;
  logic [31:0] m_cnt, m_load, m_match;
  logic [3:0]  m_ctrl;
  logic        m_pend, m_raw;

  function automatic logic [31:0] advance(logic [31:0] c);
    if (m_pend) return m_load;
    if (c != 32'hFFFF_FFFF) return c + 32'd1;
    return m_ctrl[3] ? 32'd0 : 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_cnt <= 0; m_load <= 0; m_match <= 0;
      m_ctrl <= 0; m_pend <= 0; m_raw <= 0;
    end else begin
      logic tk, hit_now;
      logic [31:0] nv;
      tk = (m_phase == DIV - 1);
      m_phase <= tk ? 0 : m_phase + 1;
      nv = advance(m_cnt);
      hit_now = tk && m_ctrl[2] && (nv == m_match);
      if (tk && m_ctrl[2]) m_cnt <= nv;
      if (bus_we && bus_addr == 5'h08) begin m_load <= bus_wdata; m_pend <= 1'b1; end
      else if (tk && m_ctrl[2]) m_pend <= 1'b0;
      if (bus_we && bus_addr == 5'h04) m_match <= bus_wdata;
      if (bus_we && bus_addr == 5'h0C) m_ctrl <= bus_wdata[3:0];
      if (hit_now) m_raw <= 1'b1;
      else if (bus_re && bus_addr == 5'h18) m_raw <= 1'b0;
    end
  end

  function automatic logic m_irq();
    return m_raw & m_ctrl[0] & ~m_ctrl[1];
  endfunction

  function automatic logic [31:0] expect_read(logic [4:0] a);
    case (a)
      5'h00: return m_cnt;
      5'h04: return m_match;
      5'h08: return m_load;
      5'h0C: return {28'd0, m_ctrl};
      5'h10: return {31'd0, m_irq()};
      5'h14: return {31'd0, m_raw};
      5'h1C: return VER;
      default: return 32'd0;
    endcase
  endfunction

  // scoreboard
  logic [31:0] q_exp[$];
  string       q_tag[$];
  logic        rd_fire = 1'b0;

  always @(posedge clk) rd_fire <= bus_re;

  always @(negedge clk) begin
    if (rd_fire && q_exp.size() > 0) begin
      logic [31:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_checks++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    q_exp.push_back(expect_read(a));
    q_tag.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic chk_irq(input string tag);
    @(negedge clk);
    n_checks++;
    if (irq_o !== m_irq()) begin
      n_fail++;
      $display("FAIL %s: irq_o got %b expected %b", tag, irq_o, m_irq());
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state, R9 version
    rd(5'h00, "R1 count"); rd(5'h04, "R1 match"); rd(5'h08, "R1 load");
    rd(5'h0C, "R1 ctrl"); rd(5'h10, "R1 mstat"); rd(5'h14, "R1 rstat");
    rd(5'h1C, "R1 version"); chk_irq("R1 irq");
    // R2 counting
    wr(5'h0C, 32'h4);
    idle(3 * DIV + 2);
    rd(5'h00, "R2 count after ticks");
    idle(DIV);
    rd(5'h00, "R2 count advanced");
    // R3 staged load
    wr(5'h08, 32'd100);
    rd(5'h00, "R3 count not yet loaded");
    rd(5'h08, "R9 load readback");
    idle(DIV + 1);
    rd(5'h00, "R3 count loaded");
    // R4 hold while disabled
    wr(5'h0C, 32'h0);
    wr(5'h08, 32'd500);
    idle(4 * DIV);
    rd(5'h00, "R4 count held");
    wr(5'h0C, 32'h4);
    idle(DIV + 1);
    rd(5'h00, "R4 pending load applied");
    // R5 wrap
    wr(5'h0C, 32'hC);
    wr(5'h08, 32'hFFFF_FFFE);
    idle(3 * DIV);
    rd(5'h00, "R5 wrapped");
    // R5 saturate
    wr(5'h0C, 32'h4);
    wr(5'h08, 32'hFFFF_FFFE);
    idle(4 * DIV);
    rd(5'h00, "R5 saturated");
    // R6 raw sets with interrupt disabled
    wr(5'h04, 32'd12);
    wr(5'h08, 32'd10);
    idle(4 * DIV);
    rd(5'h14, "R6 raw set");
    rd(5'h10, "R7 masked low ie off");
    chk_irq("R7 irq low ie off");
    wr(5'h0C, 32'h5);
    rd(5'h10, "R7 masked high");
    chk_irq("R7 irq high");
    wr(5'h0C, 32'h7);
    chk_irq("R7 irq masked");
    rd(5'h0C, "R9 ctrl readback");
    wr(5'h0C, 32'h5);
    idle(2 * DIV);
    rd(5'h14, "R6 raw sticky");
    // R8 clear by read
    rd(5'h18, "R8 eoi reads zero");
    chk_irq("R8 irq cleared");
    rd(5'h14, "R8 raw cleared");
    // R9 read-only writes ignored
    wr(5'h00, 32'h1234_5678);
    rd(5'h00, "R9 count write ignored");
    wr(5'h1C, 32'h0);
    rd(5'h1C, "R9 version write ignored");
    wr(5'h14, 32'h1);
    rd(5'h14, "R9 rstat write ignored");
    rd(5'h04, "R9 match readback");
    rd(5'h1E, "R9 unmapped");
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule